// File: doc/BRIEF.md
# Crossing-Locked Integrator and Time-Measurement Strobe Sequencer

This block runs on a fast tick clock with five ticks per 25 ns bunch crossing. It produces the control strobes that a gated charge integrator and a time-to-digital converter need in every crossing. A slower crossing clock comes in as a level. The block resamples it, finds its rising edges, and restarts a five-step phase counter on each one. The first three phases of every crossing form the integration window and the last two form the integrator discharge. A start pulse for the time measurement marks phase 0. A one-tick conversion strobe marks the final integration tick.

A small offset input moves the whole sequence by up to four ticks after the crossing edge, to make up for cable delay. A watchdog on the edge stream reports loss of lock when crossing edges stop. While lock is lost, all strobes stay low until an edge is seen again.

Top module: `xing_strobe_seq`

## Requirements
- R1: While locked, each crossing period has five phases 0 to 4. `int_gate` is high in phases 0, 1 and 2, and `int_reset` is high in phases 3 and 4.
- R2: `int_gate` and `int_reset` are never high in the same tick. While `lock_lost` is low, exactly one of them is high.
- R3: `tdc_start` is high for exactly the phase-0 tick of each crossing.
- R4: `adc_sample` is high for exactly the phase-2 tick, which is the last tick of the integration window.
- R5: With offset 0, the phase-0 tick begins at the fourth rising tick edge after the rise of `xing_clk`. This delay covers a two-stage resampler, an edge register and a registered output stage.
- R6: An `offset` value k from 0 to 4 delays phase 0 by k more ticks. Values 5 to 7 act as 4.
- R7: Every detected crossing-clock rise reloads the phase, whatever phase was running. A crossing clock that shifts therefore realigns in the next crossing.
- R8: If no rise is detected for 7 consecutive ticks, `lock_lost` rises. With the last rise of `xing_clk` at tick edge 0, `lock_lost` is still low after edge 10 and is high after edge 11. The next detected rise clears it, so it is low at the tick where phase 0 appears as R5 and R6 give.
- R9: `lock_lost` is high out of reset and stays high until the first detected rise. While it is high, all four strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, five ticks per crossing |
| rst_n | input | 1 | Active-low asynchronous reset |
| xing_clk | input | 1 | Crossing clock, sampled as a level |
| offset | input | 3 | Sequence delay in ticks after the crossing edge; clamped to 4 |
| int_gate | output | 1 | Integration window, phases 0 to 2 |
| int_reset | output | 1 | Integrator discharge, phases 3 and 4 |
| tdc_start | output | 1 | Time-measurement start, phase 0 |
| adc_sample | output | 1 | Conversion strobe, last integration tick |
| lock_lost | output | 1 | No crossing edge seen within the allowed gap |

## Verification
Every result follows a crossing-clock rise by a fixed number of ticks. Phase 0 appears four ticks after the rise plus the offset. The lock flag clears after four ticks and rises eleven ticks after the last rise. The bench drives the crossing clock on falling tick edges and samples the outputs at the next falling edge. Tick j after a rise driven at tick 0 is therefore expected to be in phase (j - 4 - offset) mod 5. Steady-state checks start only after two full crossings, so the tick where a new offset or phase is reloaded never falls inside the checked window. Resync and recovery checks begin exactly at tick 4, where the reload first becomes visible.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

    typedef struct packed {
        logic gate;
        logic rst;
        logic tdc;
        logic adc;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{gate: 1'b0, rst: 1'b0, tdc: 1'b0, adc: 1'b0};

endpackage

// File: rtl/xseq_edge_det.sv
module xseq_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xing_in,
    output logic rise
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], xing_in};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/xseq_phase_ctr.sv
module xseq_phase_ctr #(
    parameter int PERIOD     = 5,
    parameter int MAX_OFFSET = 4,
    parameter int OFS_W      = 3,
    localparam int PH_W      = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [OFS_W-1:0] offset,
    output logic [PH_W-1:0]  phase
);
    logic [PH_W-1:0]  phase_d, phase_q;
    logic [OFS_W-1:0] ofs_c;
    logic [PH_W-1:0]  load_val;

    always_comb begin
        ofs_c    = (offset > OFS_W'(MAX_OFFSET)) ? OFS_W'(MAX_OFFSET) : offset;
        load_val = (ofs_c == '0) ? '0 : PH_W'(PERIOD - int'(ofs_c));
        if (rise)
            phase_d = load_val;
        else if (phase_q == PH_W'(PERIOD - 1))
            phase_d = '0;
        else
            phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/xseq_lock_mon.sv
module xseq_lock_mon #(
    parameter int MISS_LIMIT = 6,
    localparam int GAP_W     = $clog2(MISS_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic lost
);
    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             lost;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise) begin
            st_d.gap  = '0;
            st_d.lost = 1'b0;
        end else if (st_q.gap == GAP_W'(MISS_LIMIT)) begin
            st_d.lost = 1'b1;
        end else begin
            st_d.gap = st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gap: '0, lost: 1'b1};
        else        st_q <= st_d;
    end

    assign lost = st_q.lost;
endmodule

// File: rtl/xseq_strobe_dec.sv
module xseq_strobe_dec
    import xseq_pkg::*;
#(
    parameter int INT_TICKS = 3,
    parameter int PERIOD    = 5,
    localparam int PH_W     = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            lost_in,
    output strobe_t         strobes,
    output logic            lost_out
);
    typedef struct packed {
        strobe_t s;
        logic    lost;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.lost = lost_in;
        st_d.s    = STROBE_IDLE;
        if (!lost_in) begin
            st_d.s.gate = (phase < PH_W'(INT_TICKS));
            st_d.s.rst  = (phase >= PH_W'(INT_TICKS));
            st_d.s.tdc  = (phase == '0);
            st_d.s.adc  = (phase == PH_W'(INT_TICKS - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s: STROBE_IDLE, lost: 1'b1};
        else        st_q <= st_d;
    end

    assign strobes  = st_q.s;
    assign lost_out = st_q.lost;
endmodule

// File: rtl/xing_strobe_seq.sv
module xing_strobe_seq
    import xseq_pkg::*;
#(
    parameter int INT_TICKS   = 3,
    parameter int RST_TICKS   = 2,
    parameter int MAX_OFFSET  = 4,
    parameter int OFS_W       = 3,
    parameter int MISS_LIMIT  = 6,
    parameter int SYNC_STAGES = 2,
    localparam int PERIOD     = INT_TICKS + RST_TICKS,
    localparam int PH_W       = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xing_clk,
    input  logic [OFS_W-1:0] offset,
    output logic             int_gate,
    output logic             int_reset,
    output logic             tdc_start,
    output logic             adc_sample,
    output logic             lock_lost
);
    logic            rise;
    logic            lost_raw;
    logic [PH_W-1:0] phase;
    strobe_t         strobes;

    xseq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .xing_in(xing_clk), .rise(rise)
    );

    xseq_phase_ctr #(.PERIOD(PERIOD), .MAX_OFFSET(MAX_OFFSET), .OFS_W(OFS_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .rise(rise), .offset(offset), .phase(phase)
    );

    xseq_lock_mon #(.MISS_LIMIT(MISS_LIMIT)) u_lock (
        .clk(clk), .rst_n(rst_n), .rise(rise), .lost(lost_raw)
    );

    xseq_strobe_dec #(.INT_TICKS(INT_TICKS), .PERIOD(PERIOD)) u_dec (
        .clk(clk), .rst_n(rst_n), .phase(phase), .lost_in(lost_raw),
        .strobes(strobes), .lost_out(lock_lost)
    );

    assign int_gate   = strobes.gate;
    assign int_reset  = strobes.rst;
    assign tdc_start  = strobes.tdc;
    assign adc_sample = strobes.adc;
endmodule

// File: rtl/xing_strobe_seq_chk.sv
module xing_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic int_gate,
    input logic int_reset,
    input logic tdc_start,
    input logic adc_sample,
    input logic lock_lost
);
    AST_GATE_RESET_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_gate && int_reset));                                        // R2

    AST_ONE_PHASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_lost |-> (int_gate ^ int_reset));                           // R2

    AST_TDC_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        tdc_start |-> (int_gate && !adc_sample));                         // R3

    AST_ADC_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sample |-> (int_gate && !tdc_start));                         // R4

    AST_GATE_AFTER_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_reset) && !lock_lost) |-> int_gate);                   // R1

    AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |-> !(int_gate || int_reset || tdc_start || adc_sample)); // R9
endmodule

bind xing_strobe_seq xing_strobe_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .int_gate(int_gate), .int_reset(int_reset),
    .tdc_start(tdc_start), .adc_sample(adc_sample), .lock_lost(lock_lost)
);

// File: tb/xing_strobe_seq_test.sv
module xing_strobe_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xing_clk = 1'b0;
    logic [2:0] offset = 3'd0;
    logic       int_gate, int_reset, tdc_start, adc_sample, lock_lost;
    logic [4:0] obs;
    int         n_vec = 0;
    int         n_bad = 0;
    int         cycles = 0;

    always #4 clk = ~clk;

    xing_strobe_seq uut (
        .clk(clk), .rst_n(rst_n), .xing_clk(xing_clk), .offset(offset),
        .int_gate(int_gate), .int_reset(int_reset), .tdc_start(tdc_start),
        .adc_sample(adc_sample), .lock_lost(lock_lost)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // obs = {lock_lost, int_gate, int_reset, tdc_start, adc_sample}
    task automatic tick(input logic x);
        @(negedge clk);
        obs = {lock_lost, int_gate, int_reset, tdc_start, adc_sample};
        xing_clk = x;
    endtask

    task automatic check(input string req, input int j, input logic [4:0] exp);
        n_vec = n_vec + 1;
        if (obs !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s tick %0d: actual %b expected %b (lost,gate,rst,tdc,adc)",
                     req, j, obs, exp);
        end
    endtask

    function automatic logic [4:0] phase_vec(input int j, input int ofs);
        int p;
        p = (((j - 4 - ofs) % 5) + 5) % 5;
        return {1'b0, p < 3, p >= 3, p == 0, p == 2};
    endfunction

    // Drive n crossings (3 high, 2 low ticks); check phases from tick first_chk.
    task automatic crossings(input string req, input int n, input int ofs,
                             input int first_chk, input bit lost_before);
        int eff;
        eff = (ofs > 4) ? 4 : ofs;
        offset = 3'(ofs);
        for (int c = 0; c < n; c++) begin
            for (int p = 0; p < 5; p++) begin
                int j;
                j = c * 5 + p;
                tick(p < 3);
                if (j >= first_chk)      check(req, j, phase_vec(j, eff));
                else if (lost_before)    check(req, j, 5'b10000);
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) tick(1'b0);
        check("R9 reset", 0, 5'b10000);
        rst_n = 1'b1;
        repeat (4) begin
            tick(1'b0);
            check("R9 idle", 0, 5'b10000);
        end
    endtask

    task automatic test_first_lock();
        crossings("R1 R2 R3 R4 R5 first lock", 6, 0, 4, 1'b1);
    endtask

    task automatic test_offsets();
        crossings("R6 offset 2", 4, 2, 10, 1'b0);
        crossings("R6 offset 4", 4, 4, 10, 1'b0);
        crossings("R6 offset 7 clamps", 4, 7, 10, 1'b0);
        crossings("R6 offset 1", 4, 1, 10, 1'b0);
    endtask

    task automatic test_resync();
        crossings("R7 settle", 3, 0, 10, 1'b0);
        tick(1'b1);
        tick(1'b0);
        crossings("R7 realign", 3, 0, 4, 1'b0);
    endtask

    task automatic test_lock_loss();
        crossings("R8 lock", 3, 0, 10, 1'b0);
        for (int k = 0; k < 16; k++) begin
            int j;
            j = 15 + k;
            tick(1'b0);
            if (j == 20) begin
                n_vec = n_vec + 1;
                if (obs[4] !== 1'b0) begin
                    n_bad = n_bad + 1;
                    $display("FAIL R8 tick %0d: lock_lost actual %b expected 0", j, obs[4]);
                end
            end else if (j >= 21) begin
                check("R8 R9 lost", j, 5'b10000);
            end
        end
        crossings("R8 recover", 3, 0, 4, 1'b1);
    endtask

    initial begin
        test_reset();
        test_first_lock();
        test_offsets();
        test_resync();
        test_lock_loss();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule